// File: doc/BRIEF.md
# PS/2 Device Receiver with Conditional Acknowledge

This block is the receive half of a PS/2 device port. It watches the shared open-drain clock and data lines for a host's request to send. Such a request is the clock held low for a set minimum time, then released while data is held low. After the request, the block generates its own clock pulses and shifts in one frame from the host.

Each frame holds eight data bits, least significant first, an odd parity bit and a stop bit. On the final generated pulse the block pulls data low to acknowledge the frame. When the check mode is on, it withholds that acknowledge if the parity or the stop bit is wrong.

At the end of the frame the byte is copied into a single holding register. The block reports the parity bit, a frame-error flag, an overrun flag and a receive-interrupt flag; each flag is cleared by a one-cycle pulse. Line drivers are active-high pull-down enables, so the pad ties the line low while an enable is 1 and lets it float high otherwise.

Top module: `ps2_dev_rx`

## Requirements
- R1: A reception starts only when the synchronized clock has been low for at least RTS_CYC cycles and is then seen high while the synchronized data line is low. A shorter low time starts nothing.
- R2: A reception drives exactly eleven clock pulses. Each pulse is HALF_CYC cycles low (`clk_oe`=1) followed by HALF_CYC cycles released.
- R3: The acknowledge (`dat_oe`=1) is driven only during the eleventh pulse. With `ack_check`=0 it is always driven. With `ack_check`=1 it is driven only if data plus parity hold an odd number of ones and the stop bit is 1.
- R4: The data line is sampled at the end of each of the first ten released phases, filling data bits 0..7 (LSB first), then parity, then stop. At frame end `rx_byte` takes the eight data bits and `rx_parity` takes the received parity bit.
- R5: `frame_err` sets at frame end when the stop bit was 0. It holds until a `clr_ferr` pulse.
- R6: If a frame ends while the previous byte has not been consumed by `rd_strobe`, `overrun` sets and `rx_byte` is replaced. `clr_ovf` clears the flag. A byte consumed before the next frame ends causes no overrun.
- R7: `rx_int` sets at the end of a frame whose acknowledge was driven. It clears on `clr_rxint`. `irq` is high only while `rx_int` and `rx_irq_en` are both 1.
- R8: `busy` is 1 from the first generated pulse to the end of the frame and 0 otherwise. After reset, `busy`, both drive enables, `rx_byte` and all flags are 0.
- R9: `clk_sync` and `dat_sync` follow the line levels through a two-flop synchronizer. A change shows on these outputs after two clock edges.
- R10: While `enable` is 0 the receiver stays idle, ignores requests to send, and releases both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver enable |
| ack_check | input | 1 | 1: acknowledge only frames with good parity and stop |
| rx_irq_en | input | 1 | Routes `rx_int` to `irq` |
| clr_ferr | input | 1 | Pulse to clear `frame_err` |
| clr_ovf | input | 1 | Pulse to clear `overrun` |
| clr_rxint | input | 1 | Pulse to clear `rx_int` |
| rd_strobe | input | 1 | Marks the holding register as consumed |
| clk_in | input | 1 | Level on the PS/2 clock line |
| dat_in | input | 1 | Level on the PS/2 data line |
| clk_oe | output | 1 | 1 pulls the clock line low |
| dat_oe | output | 1 | 1 pulls the data line low |
| rx_byte | output | 8 | Holding register |
| rx_parity | output | 1 | Parity bit of the last frame |
| frame_err | output | 1 | Stop bit was 0 |
| overrun | output | 1 | Holding register overwritten unread |
| rx_int | output | 1 | Receive interrupt flag |
| irq | output | 1 | Gated interrupt request |
| busy | output | 1 | Reception in progress |
| clk_sync | output | 1 | Synchronized clock line level |
| dat_sync | output | 1 | Synchronized data line level |

## Verification
The hardest conditions to reach are the ones that depend on how the host reacts to the block's own clock. These are a withheld acknowledge, a stop bit held low and an unread byte being overwritten. The bench models the open-drain lines as a wired AND of the host's and the block's pull-downs. A host task presents each next bit on every falling edge the block generates and can corrupt the parity or the stop bit on purpose. That task then reads the data line during the eleventh pulse to see whether the acknowledge arrived. Overrun is reached by sending two such frames back to back without a read strobe.

// File: rtl/ps2_dev_rx.sv
module ps2_dev_rx #(
  parameter int RTS_CYC  = 5000,
  parameter int HALF_CYC = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       ack_check,
  input  logic       rx_irq_en,
  input  logic       clr_ferr,
  input  logic       clr_ovf,
  input  logic       clr_rxint,
  input  logic       rd_strobe,
  input  logic       clk_in,
  input  logic       dat_in,
  output logic       clk_oe,
  output logic       dat_oe,
  output logic [7:0] rx_byte,
  output logic       rx_parity,
  output logic       frame_err,
  output logic       overrun,
  output logic       rx_int,
  output logic       irq,
  output logic       busy,
  output logic       clk_sync,
  output logic       dat_sync
);
  localparam int RW = $clog2(RTS_CYC + 1);
  localparam int TW = $clog2(HALF_CYC + 1);
  localparam logic [3:0] LAST = 4'd10;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_t;

  st_t           st;
  logic [1:0]    cff, dff;
  logic [RW-1:0] rts_cnt;
  logic [TW-1:0] tcnt;
  logic [3:0]    bitk;
  logic [9:0]    shreg;
  logic          unread;

  wire clk_s     = cff[1];
  wire dat_s     = dff[1];
  wire phase_end = (tcnt == TW'(HALF_CYC - 1));
  wire ack_ok    = !ack_check || ((^shreg[8:0]) && shreg[9]);
  wire commit    = enable && (st == S_HIGH) && phase_end && (bitk == LAST);

  assign clk_sync = clk_s;
  assign dat_sync = dat_s;
  assign clk_oe   = (st == S_LOW);
  assign dat_oe   = (st != S_IDLE) && (bitk == LAST) && ack_ok;
  assign busy     = (st != S_IDLE);
  assign irq      = rx_int && rx_irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cff <= 2'b11;
      dff <= 2'b11;
      st <= S_IDLE;
      rts_cnt <= '0;
      tcnt <= '0;
      bitk <= '0;
      shreg <= '0;
    end else begin
      cff <= {cff[0], clk_in};
      dff <= {dff[0], dat_in};
      if (!enable) begin
        st <= S_IDLE;
        rts_cnt <= '0;
        tcnt <= '0;
        bitk <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            if (!clk_s) begin
              if (rts_cnt != RW'(RTS_CYC)) rts_cnt <= rts_cnt + 1'b1;
            end else begin
              rts_cnt <= '0;
              if (rts_cnt == RW'(RTS_CYC) && !dat_s) begin
                st <= S_LOW;
                tcnt <= '0;
                bitk <= '0;
              end
            end
          end
          S_LOW: begin
            tcnt <= tcnt + 1'b1;
            if (phase_end) begin
              tcnt <= '0;
              st <= S_HIGH;
            end
          end
          S_HIGH: begin
            tcnt <= tcnt + 1'b1;
            if (phase_end) begin
              tcnt <= '0;
              if (bitk == LAST) begin
                st <= S_IDLE;
                bitk <= '0;
              end else begin
                shreg <= {dat_s, shreg[9:1]};
                bitk <= bitk + 1'b1;
                st <= S_LOW;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0;
      rx_parity <= 1'b0;
      frame_err <= 1'b0;
      overrun <= 1'b0;
      rx_int <= 1'b0;
      unread <= 1'b0;
    end else begin
      if (commit) begin
        rx_byte <= shreg[7:0];
        rx_parity <= shreg[8];
      end
      if (commit && !shreg[9]) frame_err <= 1'b1;
      else if (clr_ferr) frame_err <= 1'b0;
      if (commit && unread) overrun <= 1'b1;
      else if (clr_ovf) overrun <= 1'b0;
      if (commit && ack_ok) rx_int <= 1'b1;
      else if (clr_rxint) rx_int <= 1'b0;
      if (commit) unread <= 1'b1;
      else if (rd_strobe) unread <= 1'b0;
    end
  end

  assert_start_on_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(clk_s) && !$past(dat_s));
  assert_ferr_from_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> !$past(shreg[9]));
  assert_ovf_needs_unread_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(unread));
  assert_int_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_int) |-> $past(dat_oe));
  assert_lines_free_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !clk_oe && !dat_oe && !busy);
endmodule

// File: tb/sim_ps2_dev_rx.sv
module sim_ps2_dev_rx;
  localparam int RTS = 50;
  localparam int HALF = 20;

  logic clk = 0, rst_n = 0;
  logic enable = 0, ack_check = 0, rx_irq_en = 0;
  logic clr_ferr = 0, clr_ovf = 0, clr_rxint = 0, rd_strobe = 0;
  logic host_clk = 0, host_dat = 0;
  logic clk_oe, dat_oe, rx_parity, frame_err, overrun, rx_int, irq, busy, clk_sync, dat_sync;
  logic [7:0] rx_byte;
  logic clk_line, dat_line;
  int total = 0, bad = 0;
  int pulses = 0, run = 0, last_low = 0;
  logic ack_seen;
  bit done = 0;

  assign clk_line = ~(host_clk | clk_oe);
  assign dat_line = ~(host_dat | dat_oe);

  always #10 clk = ~clk;

  ps2_dev_rx #(.RTS_CYC(RTS), .HALF_CYC(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ack_check(ack_check), .rx_irq_en(rx_irq_en),
    .clr_ferr(clr_ferr), .clr_ovf(clr_ovf), .clr_rxint(clr_rxint), .rd_strobe(rd_strobe),
    .clk_in(clk_line), .dat_in(dat_line), .clk_oe(clk_oe), .dat_oe(dat_oe),
    .rx_byte(rx_byte), .rx_parity(rx_parity), .frame_err(frame_err), .overrun(overrun),
    .rx_int(rx_int), .irq(irq), .busy(busy), .clk_sync(clk_sync), .dat_sync(dat_sync));

  always @(negedge clk_line) pulses++;
  always @(posedge clk) begin
    if (clk_oe) run++;
    else if (run != 0) begin last_low = run; run = 0; end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_ferr = 1; clr_ovf = 1; clr_rxint = 1; rd_strobe = 1;
    @(negedge clk); clr_ferr = 0; clr_ovf = 0; clr_rxint = 0; rd_strobe = 0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    logic [9:0] bits;
    bits = {~bad_stop, (~^d) ^ bad_par, d};
    @(negedge clk); host_clk = 1;
    repeat (RTS + 10) @(negedge clk);
    host_dat = 1;
    repeat (5) @(negedge clk);
    host_clk = 0;
    pulses = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk_line); #1 host_dat = ~bits[k];
    end
    @(negedge clk_line); #1 host_dat = 0;
    @(posedge clk_line);
    repeat (3) @(negedge clk);
    ack_seen = ~dat_line;
    wait (!busy);
    @(negedge clk);
  endtask

  localparam int NV = 6;
  localparam logic [10:0] VEC [NV] = '{
    {8'hA5, 3'b000}, {8'h3C, 3'b001}, {8'h01, 3'b101},
    {8'hFF, 3'b011}, {8'h80, 3'b100}, {8'h00, 3'b010}};

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    if (!done) $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset busy", busy, 0);
    chk("R8 reset drives", {clk_oe, dat_oe}, 0);
    chk("R8 reset flags", {rx_byte, frame_err, overrun, rx_int}, 0);
    rst_n = 1;
    enable = 1; rx_irq_en = 1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] d; logic bp, bs, m, ea;
      {d, bp, bs, m} = VEC[i];
      ack_check = m;
      ea = !m || (!bp && !bs);
      send_frame(d, bp, bs);
      chk("R4 rx_byte", rx_byte, d);
      chk("R4 rx_parity", rx_parity, (~^d) ^ bp);
      chk("R3 ack on line", ack_seen, ea);
      chk("R5 frame_err", frame_err, bs);
      chk("R7 rx_int", rx_int, ea);
      chk("R7 irq", irq, ea);
      chk("R2 pulse count", pulses, 11);
      chk("R2 low width", last_low, HALF);
      pulse_clr();
      chk("R5 R7 cleared", {frame_err, rx_int}, 0);
    end

    ack_check = 0;
    @(negedge clk); host_clk = 1;
    @(negedge clk); @(negedge clk);
    chk("R9 clk_sync low", clk_sync, 0);
    host_dat = 1;
    @(negedge clk); @(negedge clk);
    chk("R9 dat_sync low", dat_sync, 0);
    host_clk = 0;
    @(negedge clk);
    chk("R9 clk_sync lag", clk_sync, 0);
    @(negedge clk);
    chk("R9 clk_sync high", clk_sync, 1);
    host_dat = 0;
    repeat (5) @(negedge clk);

    host_clk = 1;
    repeat (RTS / 2) @(negedge clk);
    host_dat = 1;
    repeat (3) @(negedge clk);
    host_clk = 0;
    repeat (100) @(negedge clk);
    chk("R1 short low ignored", busy, 0);
    chk("R1 short low no drive", clk_line, 1);
    host_dat = 0;
    repeat (5) @(negedge clk);

    send_frame(8'h11, 0, 0);
    send_frame(8'h22, 0, 0);
    chk("R6 overrun set", overrun, 1);
    chk("R6 byte replaced", rx_byte, 8'h22);
    @(negedge clk); clr_ovf = 1; @(negedge clk); clr_ovf = 0;
    chk("R6 overrun cleared", overrun, 0);
    @(negedge clk); rd_strobe = 1; @(negedge clk); rd_strobe = 0;
    send_frame(8'h33, 0, 0);
    chk("R6 consumed no overrun", overrun, 0);
    pulse_clr();

    rx_irq_en = 0;
    send_frame(8'h44, 0, 0);
    chk("R7 gated irq low", irq, 0);
    chk("R7 flag still set", rx_int, 1);
    @(negedge clk); rx_irq_en = 1; @(negedge clk);
    chk("R7 irq after enable", irq, 1);
    pulse_clr();
    chk("R7 irq after clear", irq, 0);

    enable = 0;
    @(negedge clk); host_clk = 1;
    repeat (RTS + 10) @(negedge clk);
    host_dat = 1;
    repeat (5) @(negedge clk);
    host_clk = 0;
    repeat (200) @(negedge clk);
    chk("R10 idle when disabled", busy, 0);
    chk("R10 lines released", {clk_oe, dat_oe}, 0);
    chk("R10 no frame", rx_int, 0);
    host_dat = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule